// File: doc/BRIEF.md
# Data-Path Integer ALU with Condition Flags

This block is the integer execution unit of a load/store processor's data-processing path. Each operation it accepts carries a 4-bit opcode, a first operand taken straight from a register, and a second operand that has already been through the operand shifter. With these come the current N/Z/C/V flags, the shifter's carry-out and a set-flags bit. From them the block produces a 32-bit result, a write-enable for that result, and the next-state flags.

It covers sixteen operations in five groups:

- plain and carrying addition and subtraction;
- reverse subtraction, with and without carry;
- bitwise AND, exclusive-OR, OR and bit-clear;
- test and compare operations, which only touch the flags;
- two moves that ignore the first operand.

Operations enter through a valid/ready stream and leave through a single registered output stage. The upstream side may present an operation only while `in_ready` is high. The downstream side holds `out_ready` low to stall: the registered output then stays frozen and `in_ready` drops. Register-file access, condition evaluation, shifting and multiplication belong to neighbouring blocks.

Top module: `dp_alu`

## Requirements
- R1: The opcode encoding is AND=0, EOR=1, SUB=2, RSB=3, ADD=4, ADC=5, SBC=6, RSC=7, TST=8, TEQ=9, CMP=A, CMN=B, ORR=C, MOV=D, BIC=E, MVN=F. The arithmetic results are SUB=A−B, RSB=B−A, ADD=A+B, ADC=A+B+C, SBC=A−B+C−1 and RSC=B−A+C−1, all modulo 2^32, where C is in_flags[1].
- R2: For arithmetic and compare operations with flag update, C is the carry out of the 33-bit sum: for subtraction it is 1 when there is no borrow. V is set exactly when the signed two's-complement result falls outside the 32-bit range.
- R3: AND, EOR, ORR and BIC (A AND NOT B) produce bitwise results. When they update flags, C takes in_shift_c and V keeps in_flags[0].
- R4: TST (A AND B), TEQ (A EOR B), CMP (A−B) and CMN (A+B) hold out_wr_en low and always update N, Z, C and V, whatever in_set_flags is.
- R5: MOV yields B and MVN yields NOT B. Neither depends on A. Their flag rules are those of R3.
- R6: For every non-compare opcode, out_flags equals in_flags when in_set_flags is 0, and out_wr_en is 1.
- R7: When flags update, N is bit 31 of the result and Z is 1 exactly when the 32-bit result is zero. For compares, the result used is the unwritten internal one.
- R8: The flag vector layout is bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V, on both in_flags and out_flags.
- R9: in_ready is high exactly when out_valid is low or out_ready is high. While out_valid is high and out_ready is low, the output holds valid and keeps its result, write-enable and flags unchanged.
- R10: While rst_n is low, out_valid, out_result, out_wr_en and out_flags are zero.
- R11: An operation accepted on a clock edge (in_valid and in_ready both high) appears on the outputs with out_valid high right after that edge. With no accepted input and out_ready high, out_valid falls after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation presented |
| in_ready | output | 1 | Block can take an operation this cycle |
| in_op | input | 4 | Opcode |
| in_a | input | 32 | First operand (register value) |
| in_b | input | 32 | Second operand (shifter output) |
| in_flags | input | 4 | Current N, Z, C, V |
| in_shift_c | input | 1 | Shifter carry-out |
| in_set_flags | input | 1 | Request flag update |
| out_valid | output | 1 | Output stage holds an operation |
| out_ready | input | 1 | Downstream takes the output this cycle |
| out_result | output | 32 | Operation result |
| out_wr_en | output | 1 | Result is to be written back |
| out_flags | output | 4 | Next-state N, Z, C, V |

## Verification
The hardest cases to reach are the carry-consuming subtractions, SBC and RSC. With operands at the signed boundaries (0x7FFFFFFF, 0x80000000, 0xFFFFFFFF, 0), carry-in and borrow interact with the overflow rule, and a mistake shows only for particular pairings. The stimulus therefore crosses every opcode with every ordered pair from a set of boundary and pattern operands, under all combinations of carry-in, shifter carry and set-flags. Expected values come from 64-bit signed and unsigned arithmetic. A separate sequence stalls the output while a new operation waits at the input, so that hold and refusal are observed together.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'h0,
    OP_EOR = 4'h1,
    OP_SUB = 4'h2,
    OP_RSB = 4'h3,
    OP_ADD = 4'h4,
    OP_ADC = 4'h5,
    OP_SBC = 4'h6,
    OP_RSC = 4'h7,
    OP_TST = 4'h8,
    OP_TEQ = 4'h9,
    OP_CMP = 4'hA,
    OP_CMN = 4'hB,
    OP_ORR = 4'hC,
    OP_MOV = 4'hD,
    OP_BIC = 4'hE,
    OP_MVN = 4'hF
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  localparam int FLAG_W = $bits(flags_t);

  function automatic logic op_is_compare(alu_op_e op);
    return op inside {OP_TST, OP_TEQ, OP_CMP, OP_CMN};
  endfunction

  function automatic logic op_uses_adder(alu_op_e op);
    return op inside {OP_SUB, OP_RSB, OP_ADD, OP_ADC,
                      OP_SBC, OP_RSC, OP_CMP, OP_CMN};
  endfunction

endpackage

// File: rtl/dp_alu_adder.sv
module dp_alu_adder
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           carry_in,
  output logic [W-1:0]   sum,
  output logic           carry_out,
  output logic           overflow
);

  logic [W-1:0] x;
  logic [W-1:0] y;
  logic         ci;
  logic [W:0]   wide;

  // One adder serves all arithmetic: operands are swapped for reverse
  // forms and inverted for subtraction forms.
  always_comb begin
    unique case (op)
      OP_SUB, OP_CMP: begin x = a; y = ~b; ci = 1'b1;     end
      OP_RSB:         begin x = b; y = ~a; ci = 1'b1;     end
      OP_ADC:         begin x = a; y = b;  ci = carry_in; end
      OP_SBC:         begin x = a; y = ~b; ci = carry_in; end
      OP_RSC:         begin x = b; y = ~a; ci = carry_in; end
      default:        begin x = a; y = b;  ci = 1'b0;     end
    endcase
  end

  assign wide      = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  assign sum       = wide[W-1:0];
  assign carry_out = wide[W];
  assign overflow  = (x[W-1] == y[W-1]) && (wide[W-1] != x[W-1]);

endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  always_comb begin
    unique case (op)
      OP_AND, OP_TST: y = a & b;
      OP_EOR, OP_TEQ: y = a ^ b;
      OP_ORR:         y = a | b;
      OP_BIC:         y = a & ~b;
      OP_MOV:         y = b;
      OP_MVN:         y = ~b;
      default:        y = '0;
    endcase
  end

endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic         set_flags,
  input  flags_t       cur,
  input  logic [W-1:0] result,
  input  logic         add_c,
  input  logic         add_v,
  input  logic         shift_c,
  output flags_t       nxt,
  output logic         wr_en
);

  logic   cmp;
  logic   arith;
  logic   update;
  flags_t fresh;

  assign cmp    = op_is_compare(op);
  assign arith  = op_uses_adder(op);
  assign update = set_flags | cmp;
  assign wr_en  = ~cmp;

  always_comb begin
    fresh.n = result[W-1];
    fresh.z = (result == '0);
    fresh.c = arith ? add_c : shift_c;
    fresh.v = arith ? add_v : cur.v;
    nxt     = update ? fresh : cur;
  end

endmodule

// File: rtl/dp_alu_stage.sv
module dp_alu_stage #(
  parameter int DW = 37
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);

  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [3:0]   in_op,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [3:0]   in_flags,
  input  logic         in_shift_c,
  input  logic         in_set_flags,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_result,
  output logic         out_wr_en,
  output logic [3:0]   out_flags
);

  localparam int DW = W + 1 + FLAG_W;

  alu_op_e      op;
  flags_t       cur;
  flags_t       nxt;
  logic [W-1:0] sum;
  logic [W-1:0] lres;
  logic [W-1:0] res;
  logic         add_c;
  logic         add_v;
  logic         wr_en;
  logic [DW-1:0] stage_in;
  logic [DW-1:0] stage_out;

  assign op  = alu_op_e'(in_op);
  assign cur = flags_t'(in_flags);

  dp_alu_adder #(.W(W)) u_adder (
    .op(op), .a(in_a), .b(in_b), .carry_in(cur.c),
    .sum(sum), .carry_out(add_c), .overflow(add_v)
  );

  dp_alu_logic #(.W(W)) u_logic (
    .op(op), .a(in_a), .b(in_b), .y(lres)
  );

  assign res = op_uses_adder(op) ? sum : lres;

  dp_alu_flags #(.W(W)) u_flags (
    .op(op), .set_flags(in_set_flags), .cur(cur), .result(res),
    .add_c(add_c), .add_v(add_v), .shift_c(in_shift_c),
    .nxt(nxt), .wr_en(wr_en)
  );

  assign stage_in = {res, wr_en, nxt};

  dp_alu_stage #(.DW(DW)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(stage_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(stage_out)
  );

  assign out_result = stage_out[DW-1 -: W];
  assign out_wr_en  = stage_out[FLAG_W];
  assign out_flags  = stage_out[FLAG_W-1:0];

endmodule

// File: rtl/dp_alu_checker.sv
module dp_alu_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [3:0]   in_op,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic [3:0]   in_flags,
  input logic         in_shift_c,
  input logic         in_set_flags,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_result,
  input logic         out_wr_en,
  input logic [3:0]   out_flags
);

  logic acc;
  logic is_cmp;
  logic is_bitwise;
  assign acc        = in_valid && in_ready;
  assign is_cmp     = (in_op[3:2] == 2'b10);
  assign is_bitwise = (in_op == 4'h0) || (in_op == 4'h1) ||
                      (in_op == 4'hC) || (in_op == 4'hE);

  p_cmp_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_cmp |=> out_valid && !out_wr_en);

  p_flag_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !is_cmp && !in_set_flags |=> out_wr_en && (out_flags == $past(in_flags)));

  p_bitwise_cv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_bitwise && in_set_flags |=>
      (out_flags[0] == $past(in_flags[0])) && (out_flags[1] == $past(in_shift_c)));

  p_move_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_op == 4'hD) |=> out_result == $past(in_b));

  p_nz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_set_flags && !is_cmp |=>
      (out_flags[2] == (out_result == '0)) && (out_flags[3] == out_result[W-1]));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=>
      out_valid && $stable(out_result) && $stable(out_flags) && $stable(out_wr_en));

  p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

endmodule

bind dp_alu dp_alu_checker #(.W(W)) u_chk (.*);

// File: tb/dp_alu_bench.sv
module dp_alu_bench;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [3:0]   in_op = '0;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic [3:0]   in_flags = '0;
  logic         in_shift_c = 1'b0;
  logic         in_set_flags = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_result;
  logic         out_wr_en;
  logic [3:0]   out_flags;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dp_alu #(.W(W)) u_dp_alu (.*);

  task automatic chk(string req, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference model, written from the requirements with 64-bit arithmetic.
  task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] f, input logic sc, input logic sf,
                       output logic [31:0] r, output logic wr, output logic [3:0] nf);
    longint c;
    longint t;
    longint s;
    logic   arith;
    logic   sub;
    logic   rev;
    logic   cflag;
    logic   vflag;
    c = longint'(f[1]);
    arith = 1'b1; sub = 1'b0; rev = 1'b0;
    t = 0; s = 0;
    case (op)
      4'h2, 4'hA: begin sub = 1; t = 0; end
      4'h3:       begin sub = 1; rev = 1; t = 0; end
      4'h4, 4'hB: t = 0;
      4'h5:       t = c;
      4'h6:       begin sub = 1; t = c - 1; end
      4'h7:       begin sub = 1; rev = 1; t = c - 1; end
      default:    arith = 1'b0;
    endcase
    cflag = sc; vflag = f[0]; r = '0;
    if (arith) begin
      longint ua, ub, sa, sb;
      ua = rev ? longint'(b) : longint'(a);
      ub = rev ? longint'(a) : longint'(b);
      sa = rev ? longint'($signed(b)) : longint'($signed(a));
      sb = rev ? longint'($signed(a)) : longint'($signed(b));
      if (sub) begin
        t = ua - ub + t;
        cflag = (t >= 0);
        s = sa - sb + ((op == 4'h6 || op == 4'h7) ? c - 1 : 0);
      end else begin
        t = ua + ub + t;
        cflag = t[32];
        s = sa + sb + ((op == 4'h5) ? c : 0);
      end
      r = t[31:0];
      vflag = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    end else begin
      case (op)
        4'h0, 4'h8: r = a & b;
        4'h1, 4'h9: r = a ^ b;
        4'hC:       r = a | b;
        4'hD:       r = b;
        4'hE:       r = a & ~b;
        default:    r = ~b;
      endcase
    end
    wr = (op[3:2] != 2'b10);
    if (sf || !wr) nf = {r[31], (r == 0), cflag, vflag};
    else           nf = f;
  endtask

  function automatic string req_of(logic [3:0] op);
    if (op[3:2] == 2'b10) return "R4";
    if (op == 4'hD || op == 4'hF) return "R5";
    if (op == 4'h0 || op == 4'h1 || op == 4'hC || op == 4'hE) return "R3";
    return "R1";
  endfunction

  // Called just after a falling edge; returns just after the next falling edge.
  task automatic xfer(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                      input logic [3:0] f, input logic sc, input logic sf);
    logic [31:0] er;
    logic        ew;
    logic [3:0]  ef;
    string       rq;
    string       fr;
    model(op, a, b, f, sc, sf, er, ew, ef);
    rq = req_of(op);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    in_flags = f; in_shift_c = sc; in_set_flags = sf;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11", "out_valid", longint'(out_valid), 1);
    chk(rq, "wr_en", longint'(out_wr_en), longint'(ew));
    if (ew) chk(rq, "result", longint'(out_result), longint'(er));
    if (op[3:2] != 2'b10 && !sf) fr = "R6";
    else if (rq == "R1") fr = "R2";
    else fr = rq;
    chk(fr, "flags NZCV (R7 R8)", longint'(out_flags), longint'(ef));
  endtask

  initial begin
    logic [31:0] vals [8];
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001;
    vals[2] = 32'h7FFF_FFFF; vals[3] = 32'h8000_0000;
    vals[4] = 32'hFFFF_FFFF; vals[5] = 32'h1234_5678;
    vals[6] = 32'hEDCB_A987; vals[7] = 32'h8000_0001;

    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "out_valid in reset", longint'(out_valid), 0);
    chk("R10", "out_flags in reset", longint'(out_flags), 0);
    chk("R10", "out_result in reset", longint'(out_result), 0);
    chk("R10", "out_wr_en in reset", longint'(out_wr_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "in_ready idle", longint'(in_ready), 1);

    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          for (int m = 0; m < 8; m++) begin
            logic [3:0] f;
            f = {i[0], j[0], m[0], i[1] ^ j[1]};
            xfer(op[3:0], vals[i], vals[j], f, m[1], m[2]);
          end

    // R9: stall with a new operation waiting
    xfer(4'h4, 32'd5, 32'd3, 4'b0000, 1'b0, 1'b1);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 4'h2; in_a = 32'd10; in_b = 32'd4;
    in_flags = 4'b0000; in_shift_c = 1'b0; in_set_flags = 1'b1;
    @(negedge clk);
    chk("R9", "in_ready while stalled", longint'(in_ready), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R9", "held result", longint'(out_result), 8);
    chk("R9", "held valid", longint'(out_valid), 1);
    chk("R9", "held flags", longint'(out_flags), 4'b0000);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9", "result after release", longint'(out_result), 6);
    chk("R2", "flags after release", longint'(out_flags), 4'b0010);
    @(posedge clk);
    @(negedge clk);
    chk("R11", "valid drops when idle", longint'(out_valid), 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule